// File: doc/BRIEF.md
# Clock Multiplier Lock-Up Sequencer

This block controls two clock multiplier units that sit outside it: a general-purpose unit whose factor is chosen between x12 and x16, and a unit dedicated to USB clocking. Software writes a small control word that asks for each unit and picks the general unit's factor. The block then drives the enable and factor-select lines to the analog cores. It times each unit's settling interval with a binary counter running on the oscillator clock, and raises a lock flag that software polls before it switches to the multiplied clock.

The two units are never allowed to settle at the same time. A unit that is asked for while the other one is still settling waits, with its analog enable low. It starts its own full count one cycle after the other unit's lock flag rises. If both are asked for in the same write, the general unit goes first. Turning a unit off clears its count and its lock flag, and turning it on again restarts the whole interval. Changing the factor select while the general unit is enabled also restarts that unit's interval.

Top module: `pll_lock_seq`

## Requirements
- R1: After a synchronous reset, `rdData` is all zero and both `genPllOn` and `usbPllOn` are low.
- R2: A write (`wrEn` high at a clock edge) stores `wrData[0]` as the general-unit request, `wrData[1]` as the USB-unit request and `wrData[2]` as the factor select (1 = x16). From the next cycle these read back on `rdData[0]`, `rdData[1]` and `rdData[2]`.
- R3: The general unit settles in 2^GEN_STAGES (4096) counting cycles. Its lock flag, `rdData[3]`, rises 4097 cycles after the enabling write edge when the USB unit is not settling.
- R4: The USB unit settles in 2^USB_STAGES (8192) counting cycles. Its lock flag, `rdData[4]`, rises 8193 cycles after the enabling write edge when the general unit is not settling.
- R5: The two units never settle at the same time. When both are requested in one write, the general unit settles first.
- R6: A unit requested while the other one is settling is held pending. Its count starts in the cycle after the other unit's lock flag rises, so its flag rises its full interval plus one cycle after that.
- R7: Clearing a unit's request bit drops its lock flag and its analog enable one cycle after the write edge. The other unit is left untouched.
- R8: Re-enabling a unit after a disable restarts its full interval from zero, whatever count it had reached before.
- R9: A write that changes the factor select while the general unit is requested clears its lock flag and restarts its 4096-cycle interval. The flag then rises 4097 cycles after that write edge.
- R10: `mult16` follows the stored factor select from the cycle after the write.
- R11: A unit's analog enable (`genPllOn`, `usbPllOn`) is high while that unit is settling or locked, and low while it is pending or off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | High-frequency oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Control-word write strobe |
| wrData | input | 3 | Control word: bit0 general request, bit1 USB request, bit2 x16 select |
| rdData | output | 5 | Read-back: bits 2:0 control word, bit3 general lock, bit4 USB lock |
| genPllOn | output | 1 | Enable to the general multiplier core |
| usbPllOn | output | 1 | Enable to the USB multiplier core |
| mult16 | output | 1 | Factor select to the general core (1 = x16, 0 = x12) |

## Verification
The write lands in the control registers at edge E. A unit that is free to start enters its counting state at E+1, so its enable is due one cycle after the write, and its lock is due after E+1+2^STAGES. A disable or a select change takes effect at E+1. A pending unit's lock is due 2^STAGES+1 edges after the edge where the other unit's lock rose. The bench drives on falling edges and samples on falling edges. For each timing it checks the lock flag one cycle before it is due (expecting 0) and at the cycle it is due (expecting 1), so an off-by-one in either direction shows up. Where the start edge of a pending count depends on earlier activity, the bench polls for the first unit's lock with a bounded loop, checks the poll count against the computed value, and measures the second interval from that point.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  typedef enum logic [1:0] {
    UNIT_OFF    = 2'd0,
    UNIT_WAIT   = 2'd1,
    UNIT_COUNT  = 2'd2,
    UNIT_LOCKED = 2'd3
  } unitState_t;

  // index 0 = general unit, index 1 = USB unit
  typedef struct packed {
    logic [1:0] clr;
    logic [1:0] inc;
  } cntStrobe_t;

endpackage

// File: rtl/lock_counter.sv
module lock_counter #(
  parameter int STAGES = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic term
);
  logic [STAGES-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

  assign term = &cnt;

  // R3/R4: terminal count is never followed by a wrap-around increment
  assert_no_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    term |=> (cnt == '0));

endmodule

// File: rtl/pll_seq_datapath.sv
module pll_seq_datapath
  import pll_seq_pkg::*;
#(
  parameter int GEN_STAGES = 12,
  parameter int USB_STAGES = 13
) (
  input  logic       clk,
  input  logic       rst,
  input  cntStrobe_t strobe,
  output logic [1:0] term
);
  localparam int NUM_UNITS = 2;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    localparam int STG = (u == 0) ? GEN_STAGES : USB_STAGES;
    lock_counter #(.STAGES(STG)) u_cnt (
      .clk  (clk),
      .rst  (rst),
      .clr  (strobe.clr[u]),
      .inc  (strobe.inc[u]),
      .term (term[u])
    );
  end

endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
  import pll_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wrEn,
  input  logic [2:0] wrData,
  input  logic [1:0] term,
  output cntStrobe_t strobe,
  output logic [4:0] rdData,
  output logic       genPllOn,
  output logic       usbPllOn,
  output logic       mult16
);
  localparam int BIT_GEN = 0;
  localparam int BIT_USB = 1;
  localparam int BIT_SEL = 2;

  logic reqGen, reqUsb, sel16, selChg;
  unitState_t genSt, usbSt, genNext, usbNext;
  logic genCounting, usbCounting, usbBlocked, genRestart;

  always_ff @(posedge clk) begin
    if (rst) begin
      reqGen <= 1'b0;
      reqUsb <= 1'b0;
      sel16  <= 1'b0;
      selChg <= 1'b0;
      genSt  <= UNIT_OFF;
      usbSt  <= UNIT_OFF;
    end else begin
      if (wrEn) begin
        reqGen <= wrData[BIT_GEN];
        reqUsb <= wrData[BIT_USB];
        sel16  <= wrData[BIT_SEL];
        selChg <= (wrData[BIT_SEL] != sel16);
      end else begin
        selChg <= 1'b0;
      end
      genSt <= genNext;
      usbSt <= usbNext;
    end
  end

  assign genCounting = (genSt == UNIT_COUNT);
  assign usbCounting = (usbSt == UNIT_COUNT);

  always_comb begin
    genNext    = genSt;
    genRestart = 1'b0;
    case (genSt)
      UNIT_OFF:    if (reqGen) genNext = usbCounting ? UNIT_WAIT : UNIT_COUNT;
      UNIT_WAIT:   if (!reqGen) genNext = UNIT_OFF;
                   else if (!usbCounting) genNext = UNIT_COUNT;
      UNIT_COUNT:  if (!reqGen) genNext = UNIT_OFF;
                   else if (selChg) genRestart = 1'b1;
                   else if (term[0]) genNext = UNIT_LOCKED;
      UNIT_LOCKED: if (!reqGen) genNext = UNIT_OFF;
                   else if (selChg) begin
                     genRestart = 1'b1;
                     genNext    = usbCounting ? UNIT_WAIT : UNIT_COUNT;
                   end
      default:     genNext = UNIT_OFF;
    endcase
  end

  assign usbBlocked = genCounting || (genNext == UNIT_COUNT);

  always_comb begin
    usbNext = usbSt;
    case (usbSt)
      UNIT_OFF:    if (reqUsb) usbNext = usbBlocked ? UNIT_WAIT : UNIT_COUNT;
      UNIT_WAIT:   if (!reqUsb) usbNext = UNIT_OFF;
                   else if (!usbBlocked) usbNext = UNIT_COUNT;
      UNIT_COUNT:  if (!reqUsb) usbNext = UNIT_OFF;
                   else if (term[1]) usbNext = UNIT_LOCKED;
      UNIT_LOCKED: if (!reqUsb) usbNext = UNIT_OFF;
      default:     usbNext = UNIT_OFF;
    endcase
  end

  always_comb begin
    strobe.clr[0] = (genNext != UNIT_COUNT) || !genCounting || genRestart;
    strobe.clr[1] = (usbNext != UNIT_COUNT) || !usbCounting;
    strobe.inc[0] = !strobe.clr[0];
    strobe.inc[1] = !strobe.clr[1];
  end

  assign genPllOn = genCounting || (genSt == UNIT_LOCKED);
  assign usbPllOn = usbCounting || (usbSt == UNIT_LOCKED);
  assign mult16   = sel16;
  assign rdData   = {usbSt == UNIT_LOCKED, genSt == UNIT_LOCKED, sel16, reqUsb, reqGen};

  // R5: the two units never settle together
  assert_single_count_R5: assert property (@(posedge clk) disable iff (rst)
    !(genCounting && usbCounting));

  // R7: a dropped request turns the unit off on the next edge
  assert_disable_off_R7: assert property (@(posedge clk) disable iff (rst)
    !reqGen |=> (genSt == UNIT_OFF));

  // R3: the general unit keeps counting until terminal count
  assert_count_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (genCounting && reqGen && !selChg && !term[0]) |=> genCounting);

  // R4: the USB unit locks right after terminal count
  assert_usb_lock_R4: assert property (@(posedge clk) disable iff (rst)
    (usbCounting && reqUsb && term[1]) |=> (usbSt == UNIT_LOCKED));

  // R6: a pending USB unit starts the cycle after the general unit locks
  assert_pending_start_R6: assert property (@(posedge clk) disable iff (rst)
    ($rose(genSt == UNIT_LOCKED) && usbSt == UNIT_WAIT && reqUsb && reqGen && !selChg)
      |=> usbCounting);

  // R9: a select change drops a held lock
  assert_sel_restart_R9: assert property (@(posedge clk) disable iff (rst)
    (genSt == UNIT_LOCKED && reqGen && selChg) |=> (genSt != UNIT_LOCKED));

endmodule

// File: rtl/pll_lock_seq.sv
module pll_lock_seq
  import pll_seq_pkg::*;
#(
  parameter int GEN_STAGES = 12,
  parameter int USB_STAGES = 13
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wrEn,
  input  logic [2:0] wrData,
  output logic [4:0] rdData,
  output logic       genPllOn,
  output logic       usbPllOn,
  output logic       mult16
);
  cntStrobe_t strobe;
  logic [1:0] term;

  pll_seq_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wrEn     (wrEn),
    .wrData   (wrData),
    .term     (term),
    .strobe   (strobe),
    .rdData   (rdData),
    .genPllOn (genPllOn),
    .usbPllOn (usbPllOn),
    .mult16   (mult16)
  );

  pll_seq_datapath #(
    .GEN_STAGES (GEN_STAGES),
    .USB_STAGES (USB_STAGES)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .term   (term)
  );

endmodule

// File: tb/tb_pll_lock_seq.sv
`timescale 1ns/1ps
module tb_pll_lock_seq;
  localparam int GEN_LEN = 4096;
  localparam int USB_LEN = 8192;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrEn = 1'b0;
  logic [2:0] wrData = 3'b000;
  logic [4:0] rdData;
  logic genPllOn, usbPllOn, mult16;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pll_lock_seq dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .genPllOn(genPllOn), .usbPllOn(usbPllOn), .mult16(mult16)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic test_reset();
    check("R1 rdData", rdData, 0);
    check("R1 genPllOn", genPllOn, 0);
    check("R1 usbPllOn", usbPllOn, 0);
  endtask

  task automatic test_gen_lock();
    wr(3'b001);
    check("R2 readback", rdData[2:0], 1);
    check("R10 mult16 x12", mult16, 0);
    cyc(1);
    check("R11 gen enable", genPllOn, 1);
    cyc(GEN_LEN - 1);
    check("R3 gen lock early", rdData[3], 0);
    cyc(1);
    check("R3 gen lock due", rdData[3], 1);
  endtask

  task automatic test_disable();
    wr(3'b000);
    cyc(1);
    check("R7 gen lock cleared", rdData[3], 0);
    check("R7 gen enable off", genPllOn, 0);
  endtask

  task automatic test_reenable();
    wr(3'b001);
    cyc(2000);
    wr(3'b000);
    wr(3'b001);
    cyc(GEN_LEN);
    check("R8 restart lock early", rdData[3], 0);
    cyc(1);
    check("R8 restart lock due", rdData[3], 1);
  endtask

  task automatic test_sel_change();
    wr(3'b101);
    check("R10 mult16 x16", mult16, 1);
    check("R2 readback sel", rdData[2:0], 5);
    cyc(1);
    check("R9 lock cleared", rdData[3], 0);
    cyc(GEN_LEN - 1);
    check("R9 relock early", rdData[3], 0);
    cyc(1);
    check("R9 relock due", rdData[3], 1);
    wr(3'b000);
    wr(3'b100);
    cyc(2);
    check("R9 sel with gen off", genPllOn, 0);
    check("R10 mult16 held", mult16, 1);
    wr(3'b000);
    cyc(2);
  endtask

  task automatic test_usb_lock();
    wr(3'b010);
    cyc(1);
    check("R11 usb enable", usbPllOn, 1);
    cyc(USB_LEN - 1);
    check("R4 usb lock early", rdData[4], 0);
    cyc(1);
    check("R4 usb lock due", rdData[4], 1);
    wr(3'b000);
    cyc(2);
  endtask

  task automatic test_both_at_once();
    wr(3'b011);
    cyc(1);
    check("R5 gen first", genPllOn, 1);
    check("R11 usb pending off", usbPllOn, 0);
    cyc(GEN_LEN);
    check("R5 gen lock", rdData[3], 1);
    check("R6 usb still pending", usbPllOn, 0);
    cyc(1);
    check("R6 usb starts", usbPllOn, 1);
    cyc(USB_LEN - 1);
    check("R6 usb lock early", rdData[4], 0);
    cyc(1);
    check("R6 usb lock due", rdData[4], 1);
    wr(3'b001);
    cyc(1);
    check("R7 usb off", rdData[4], 0);
    check("R7 gen kept", rdData[3], 1);
    wr(3'b000);
    cyc(2);
  endtask

  task automatic test_usb_late();
    int n;
    wr(3'b001);
    cyc(100);
    wr(3'b011);
    n = 0;
    while (!rdData[3] && n < 2 * GEN_LEN) begin cyc(1); n++; end
    check("R6 gen lock poll", n, GEN_LEN - 101);
    check("R6 usb pending", usbPllOn, 0);
    cyc(USB_LEN);
    check("R6 late usb early", rdData[4], 0);
    cyc(1);
    check("R6 late usb due", rdData[4], 1);
    wr(3'b000);
    cyc(2);
  endtask

  task automatic test_gen_late();
    int n;
    wr(3'b010);
    cyc(10);
    wr(3'b011);
    cyc(1);
    check("R5 gen waits", genPllOn, 0);
    n = 0;
    while (!rdData[4] && n < 2 * USB_LEN) begin cyc(1); n++; end
    check("R5 usb lock poll", n, USB_LEN - 12);
    cyc(GEN_LEN);
    check("R6 late gen early", rdData[3], 0);
    cyc(1);
    check("R6 late gen due", rdData[3], 1);
  endtask

  initial begin
    repeat (250000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    test_reset();
    test_gen_lock();
    test_disable();
    test_reenable();
    test_sel_change();
    test_usb_lock();
    test_both_at_once();
    test_usb_late();
    test_gen_late();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule